// File: doc/BRIEF.md
# Bitfield Insert and Extract Unit

This unit performs the bitfield operations of a scalar execution pipe on 32-bit and 64-bit operands. It can pull a field of a given width out of a source word at a given bit offset, returning it zero-extended or sign-extended. It can deposit the low bits of a source into a window of a destination word, leaving every other destination bit alone. It can form a contiguous run of ones from a width and an offset. It can also cut a 32-bit word at a bit position into two result words.

Width and offset arrive already decoded from immediates. The field logic is purely combinational. One output register captures the result when `opValid` is high, so the result appears one clock after the request. A single control stage turns the opcode and mode into a small set of strobes. The same stage trims the width and offset to the operand size, so that every operation uses the same width and offset handling.

Top module: `bf_unit`

## Requirements
- R1: While `rst_n` is low, `resValid` is 0 and `result` is 0.
- R2: `resValid` equals `opValid` delayed by one clock. When `opValid` is 0, `result` keeps its previous value.
- R3: Opcode 0 (unsigned extract) returns the operand shifted right logically by the offset, keeping only its low width bits and zero-filling the rest.
- R4: Opcode 1 (signed extract) forms the same field as R3, then copies field bit width-1 into every higher bit of the operand-sized result.
- R5: Opcode 2 (insert) clears the width-bit window at the offset in `dstIn`, then ORs in the low width bits of `srcA` shifted left by the offset.
- R6: Opcode 3 (mask) returns ((1<<width)-1)<<offset, truncated to the operand size.
- R7: Opcode 4 (split) ignores `wideMode`. It places `srcA[31:0]` shifted right logically by `splitReg[4:0]` in `result[63:32]`, and the low `splitReg[4:0]` bits of `srcA[31:0]` in `result[31:0]`.
- R8: A width of zero makes both extracts return 0, and makes insert return the destination unchanged.
- R9: Field bits that would land above the operand's top bit are dropped, never wrapped. Extract reads zeros there, and insert and mask discard them.
- R10: With `wideMode`=0, only `fieldWidth[4:0]`, `fieldOffset[4:0]`, `srcA[31:0]` and `dstIn[31:0]` are used, and `result[63:32]` is 0 for opcodes 0 to 3. With `wideMode`=1, all six bits and all 64 bits are used.
- R11: Opcodes 5, 6 and 7 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Request strobe; captures a new result |
| opCode | input | 3 | Operation: 0 extract unsigned, 1 extract signed, 2 insert, 3 mask, 4 split |
| wideMode | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit operands |
| srcA | input | 64 | Source operand |
| dstIn | input | 64 | Destination operand for insert |
| fieldWidth | input | 6 | Field width |
| fieldOffset | input | 6 | Field offset |
| splitReg | input | 32 | Split amount register; the low 5 bits are used |
| resValid | output | 1 | Result strobe, one clock after `opValid` |
| result | output | 64 | Registered result |

## Verification
The assertions assume that the request inputs are stable around the capturing edge, and that `opValid` stays low while reset is applied. On these assumptions, a past request lines up with the result that follows one clock later. The bench holds `opValid` low during reset. It changes the request inputs only on falling edges, so each request is stable over the rising edge that captures it. The random stimulus draws all eight opcode values, both modes and full 6-bit widths and offsets. This includes combinations where the field runs past the operand's top bit.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    OP_EXTU  = 3'd0,
    OP_EXTS  = 3'd1,
    OP_INS   = 3'd2,
    OP_MASK  = 3'd3,
    OP_SPLIT = 3'd4
  } bfOp_e;

  typedef struct packed {
    logic doExtract;
    logic signExt;
    logic doInsert;
    logic doMask;
    logic doSplit;
    logic wide;
  } bfStrobe_t;
endpackage

// File: rtl/bf_ctrl.sv
module bf_ctrl
  import bf_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int FLD_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2,
  localparam int AMT_W = $clog2(HALF_W)
) (
  input  logic [2:0]       opCode,
  input  logic             wideMode,
  input  logic [FLD_W-1:0] fieldWidth,
  input  logic [FLD_W-1:0] fieldOffset,
  input  logic [HALF_W-1:0] splitReg,
  output bfStrobe_t        strobes,
  output logic [FLD_W-1:0] effWidth,
  output logic [FLD_W-1:0] effOffset,
  output logic [AMT_W-1:0] splitAmt
);
  // Narrow mode keeps only the low bits of each immediate.
  localparam logic [FLD_W-1:0] NarrowKeep = {1'b0, {(FLD_W-1){1'b1}}};

  always_comb begin
    strobes = '0;
    strobes.wide = wideMode;
    unique case (opCode)
      OP_EXTU:  strobes.doExtract = 1'b1;
      OP_EXTS: begin
        strobes.doExtract = 1'b1;
        strobes.signExt   = 1'b1;
      end
      OP_INS:   strobes.doInsert = 1'b1;
      OP_MASK:  strobes.doMask   = 1'b1;
      OP_SPLIT: strobes.doSplit  = 1'b1;
      default:  strobes.wide     = wideMode;
    endcase
  end

  assign effWidth  = wideMode ? fieldWidth  : (fieldWidth  & NarrowKeep);
  assign effOffset = wideMode ? fieldOffset : (fieldOffset & NarrowKeep);
  assign splitAmt  = splitReg[AMT_W-1:0];
endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
  import bf_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int FLD_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2,
  localparam int AMT_W = $clog2(HALF_W)
) (
  input  bfStrobe_t         strobes,
  input  logic [FLD_W-1:0]  effWidth,
  input  logic [FLD_W-1:0]  effOffset,
  input  logic [AMT_W-1:0]  splitAmt,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] dstIn,
  output logic [DATA_W-1:0] dpResult
);
  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] srcOp;
  logic [DATA_W-1:0] dstOp;
  logic [DATA_W-1:0] onesLow;
  logic [DATA_W-1:0] windowMask;
  logic [DATA_W-1:0] fieldBits;
  logic [DATA_W-1:0] signedBits;
  logic [DATA_W-1:0] extractRes;
  logic [DATA_W-1:0] insertRes;
  logic [DATA_W-1:0] splitRes;
  logic              signBit;

  assign sizeMask = strobes.wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign srcOp    = srcA & sizeMask;
  assign dstOp    = dstIn & sizeMask;

  // Low run of width ones; the shift left drops anything past the top bit.
  assign onesLow    = (DATA_W'(1) << effWidth) - DATA_W'(1);
  assign windowMask = (onesLow << effOffset) & sizeMask;

  assign fieldBits = (srcOp >> effOffset) & onesLow;
  assign signBit   = (effWidth != '0) && fieldBits[effWidth - FLD_W'(1)];

  for (genvar i = 0; i < DATA_W; i++) begin : g_sext
    assign signedBits[i] = (effWidth > FLD_W'(i)) ? fieldBits[i] : signBit;
  end

  assign extractRes = (strobes.signExt ? signedBits : fieldBits) & sizeMask;
  assign insertRes  = (dstOp & ~windowMask) | (((srcOp & onesLow) << effOffset) & sizeMask);

  logic [HALF_W-1:0] splitWord;
  logic [HALF_W-1:0] splitLowMask;
  assign splitWord    = srcA[HALF_W-1:0];
  assign splitLowMask = (HALF_W'(1) << splitAmt) - HALF_W'(1);
  assign splitRes     = {splitWord >> splitAmt, splitWord & splitLowMask};

  always_comb begin
    dpResult = '0;
    if (strobes.doExtract)    dpResult = extractRes;
    else if (strobes.doInsert) dpResult = insertRes;
    else if (strobes.doMask)   dpResult = windowMask;
    else if (strobes.doSplit)  dpResult = splitRes;
  end
endmodule

// File: rtl/bf_unit.sv
module bf_unit
  import bf_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int FLD_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2,
  localparam int AMT_W = $clog2(HALF_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [FLD_W-1:0]  fieldWidth,
  input  logic [FLD_W-1:0]  fieldOffset,
  input  logic [HALF_W-1:0] splitReg,
  output logic              resValid,
  output logic [DATA_W-1:0] result
);
  bfStrobe_t         strobes;
  logic [FLD_W-1:0]  effWidth;
  logic [FLD_W-1:0]  effOffset;
  logic [AMT_W-1:0]  splitAmt;
  logic [DATA_W-1:0] dpResult;

  bf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .opCode(opCode), .wideMode(wideMode), .fieldWidth(fieldWidth),
    .fieldOffset(fieldOffset), .splitReg(splitReg), .strobes(strobes),
    .effWidth(effWidth), .effOffset(effOffset), .splitAmt(splitAmt)
  );

  bf_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes(strobes), .effWidth(effWidth), .effOffset(effOffset),
    .splitAmt(splitAmt), .srcA(srcA), .dstIn(dstIn), .dpResult(dpResult)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      result   <= '0;
    end else begin
      resValid <= opValid;
      if (opValid) result <= dpResult;
    end
  end
endmodule

// File: rtl/bf_unit_chk.sv
module bf_unit_chk #(
  parameter int DATA_W = 64,
  localparam int FLD_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic              wideMode,
  input logic [DATA_W-1:0] dstIn,
  input logic [FLD_W-1:0]  fieldWidth,
  input logic [HALF_W-1:0] splitReg,
  input logic              resValid,
  input logic [DATA_W-1:0] result
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    if (!rst_n) assert (!resValid && result == '0) else $error("p_reset_r1");
  end

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> resValid == $past(opValid));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(opValid) |-> $stable(result));

  p_narrow_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(opValid && !wideMode && opCode < 3'd4) |-> result[DATA_W-1:HALF_W] == '0);

  p_zero_ins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(opValid && wideMode && opCode == 3'd2 && fieldWidth == '0) |-> result == $past(dstIn));

  p_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(opValid && opCode <= 3'd1 && fieldWidth == '0) |-> result == '0);

  p_split_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(opValid && opCode == 3'd4) |-> (result[HALF_W-1:0] >> $past(splitReg[4:0])) == '0);

  p_unused_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(opValid && opCode > 3'd4) |-> result == '0);
endmodule

bind bf_unit bf_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
  .wideMode(wideMode), .dstIn(dstIn), .fieldWidth(fieldWidth),
  .splitReg(splitReg), .resValid(resValid), .result(result)
);

// File: tb/sim_bf_unit.sv
`timescale 1ns/1ps
module sim_bf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic        wideMode = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] dstIn = '0;
  logic [5:0]  fieldWidth = '0;
  logic [5:0]  fieldOffset = '0;
  logic [31:0] splitReg = '0;
  logic        resValid;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  bf_unit u0 (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .wideMode(wideMode), .srcA(srcA), .dstIn(dstIn), .fieldWidth(fieldWidth),
    .fieldOffset(fieldOffset), .splitReg(splitReg), .resValid(resValid), .result(result)
  );

  function automatic logic [63:0] refCalc(input logic [2:0] op, input logic wide,
      input logic [63:0] a, input logic [63:0] d, input logic [5:0] w, input logic [5:0] o,
      input logic [31:0] sr);
    logic [63:0] r;
    int n, wi, oi, amt;
    logic s;
    r = '0;
    n = wide ? 64 : 32;
    wi = wide ? int'(w) : int'(w[4:0]);
    oi = wide ? int'(o) : int'(o[4:0]);
    amt = int'(sr[4:0]);
    case (op)
      3'd0, 3'd1: begin
        for (int i = 0; i < wi; i++) if (i + oi < n) r[i] = a[i + oi];
        if (op == 3'd1 && wi > 0) begin
          s = r[wi - 1];
          for (int i = wi; i < n; i++) r[i] = s;
        end
      end
      3'd2: begin
        for (int i = 0; i < n; i++) r[i] = d[i];
        for (int i = 0; i < wi; i++) if (i + oi < n) r[i + oi] = a[i];
      end
      3'd3: for (int i = 0; i < wi; i++) if (i + oi < n) r[i + oi] = 1'b1;
      3'd4: begin
        for (int i = 0; i < 32; i++) if (i + amt < 32) r[32 + i] = a[i + amt];
        for (int i = 0; i < amt; i++) r[i] = a[i];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tagFor(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic checkVal(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic [2:0] op, input logic wide,
      input logic [63:0] a, input logic [63:0] d, input logic [5:0] w, input logic [5:0] o,
      input logic [31:0] sr);
    logic [63:0] exp;
    exp = refCalc(op, wide, a, d, w, o, sr);
    opValid = 1'b1; opCode = op; wideMode = wide; srcA = a; dstIn = d;
    fieldWidth = w; fieldOffset = o; splitReg = sr;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    checkVal({tag, " valid"}, {63'd0, resValid}, 64'd1);
    checkVal(tag, result, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checkVal("R1 reset result", result, 64'd0);
    checkVal("R1 reset valid", {63'd0, resValid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    runOp("R3 basic", 3'd0, 1'b1, 64'hFEDC_BA98_7654_3210, '0, 6'd8, 6'd12, '0);
    runOp("R4 negative field", 3'd1, 1'b1, 64'h0000_0000_0000_0F00, '0, 6'd4, 6'd8, '0);
    runOp("R4 narrow sign", 3'd1, 1'b0, 64'h0000_0000_8000_0000, '0, 6'd1, 6'd31, '0);
    runOp("R5 insert", 3'd2, 1'b1, 64'h0000_0000_0000_00AB, 64'hFFFF_FFFF_FFFF_FFFF, 6'd8, 6'd20, '0);
    runOp("R6 mask", 3'd3, 1'b0, '0, '0, 6'd5, 6'd3, '0);
    runOp("R7 split amt 0", 3'd4, 1'b0, 64'h1234_5678_9ABC_DEF0, '0, '0, '0, 32'hFFFF_FFE0);
    runOp("R7 split amt 31", 3'd4, 1'b1, 64'h0000_0000_DEAD_BEEF, '0, '0, '0, 32'd31);
    runOp("R8 extract zero width", 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, 6'd0, 6'd5, '0);
    runOp("R8 insert zero width", 3'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 6'd0, 6'd9, '0);
    runOp("R9 extract past top", 3'd1, 1'b1, 64'hF000_0000_0000_0000, '0, 6'd10, 6'd60, '0);
    runOp("R9 insert past top", 3'd2, 1'b0, 64'h0000_0000_0000_0FFF, 64'h0, 6'd10, 6'd28, '0);
    runOp("R9 mask past top", 3'd3, 1'b1, '0, '0, 6'd63, 6'd40, '0);
    runOp("R10 narrow width bit5 ignored", 3'd0, 1'b0, 64'hFFFF_FFFF_0000_00FF, '0, 6'd36, 6'd32, '0);
    runOp("R10 narrow insert top", 3'd2, 1'b0, 64'h0, 64'hAAAA_AAAA_5555_5555, 6'd4, 6'd0, '0);
    runOp("R11 unused op", 3'd6, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd8, 6'd0, '0);

    // Idle cycle: valid drops, result holds
    held = result;
    opCode = 3'd3; fieldWidth = 6'd7; srcA = '1;
    @(posedge clk);
    @(negedge clk);
    checkVal("R2 idle valid", {63'd0, resValid}, 64'd0);
    checkVal("R2 idle hold", result, held);

    // Constrained random
    for (int k = 0; k < 600; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      runOp(tagFor(op), op, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
            6'($urandom), 6'($urandom), $urandom);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule